// File: doc/BRIEF.md
# Boot-Block Flash Host Bus Front End

This block is the host-facing side of a small boot-block flash device. The host drives it with asynchronous, active-low strobes: chip select, output enable, write enable and a reset pin. It also drives a write-protect pin, a byte/word width select, an address bus and a 16-bit data bus. Two single-bit flags stand in for a high-voltage level on address bit 9 and on the reset pin. The strobes pass through two-flop synchronizers into the internal clock domain. A rising write strobe with the chip selected latches the address and data. The latched byte then goes to a command decoder that handles a two-cycle program sequence and a small status register.

A register array stands in for the flash cells. Its words reset to all ones, and programming can only clear bits. The lowest words form a boot block. A program aimed at the boot block is refused when write-protect is low, unless the high-voltage reset flag overrides it. On a read, the block selects one source to drive: array data, a signature word or the status byte. Output-enable lines tell the pad logic when each half of the bus is driven. In byte mode the top data pin is reused as the least significant byte-address bit.

Top module: `bbf_host_port`

## Requirements
- R1: Address and data are taken only when the synchronized write enable rises while the synchronized chip select is low. A write pulse made while chip select is high changes neither the mode nor the array.
- R2: A program takes two write cycles. The first carries command byte 0x40, and the second carries the target address and data. Only the second write changes the array, and after it reads return the status byte.
- R3: Both output-enable outputs are low, and the data output is zero, whenever chip select is high, output enable is high or the reset pin is low.
- R4: While the reset pin is low, a pending program setup is cancelled, the busy countdown stops and the status error bits clear. After the pin returns high, reads return array data and the status byte reads 0x80.
- R5: Words 0 to BOOT_WORDS-1 (default 4) form the boot block. A program there with write-protect low and the high-voltage reset flag clear leaves the array unchanged. It also sets status bit 4 (program error) and bit 1 (locked). Either write-protect high or the high-voltage reset flag allows the program.
- R6: With the high-voltage address flag set, reads return the manufacturer ID (default 0x00A5) when address bit 0 is 0 and the device ID (default 0x7E21) when it is 1. In byte mode only the low byte of the ID is driven, whatever the top data pin carries.
- R7: In byte mode (width select low), the byte address is the word address followed by data pin 15. Data pin 15 = 0 selects bits 7:0 of the word and 1 selects bits 15:8. Only the low output-enable is asserted. A byte-mode program changes only the selected byte.
- R8: Commands are decoded from data bits 7:0 alone. 0xFF selects array reads, 0x70 selects status reads, 0x50 clears status bits 4 and 1, and 0x40 starts a program. Any other byte selects array reads.
- R9: A program stores the bitwise AND of the old word and the written data. A bit already at zero stays zero.
- R10: After each accepted program, status bit 7 (ready) reads 0 for BUSY_CYCLES clocks (default 40) and then returns to 1. Status reads in word mode drive bits 15:8 as zero. Writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| sys_rst_n | input | 1 | Power-on reset, active low; also returns the array to all ones |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; data is latched on its rising edge |
| rp_n | input | 1 | Reset pin, active low |
| rp_hv | input | 1 | High-voltage level present on the reset pin (boot unlock) |
| wp_n | input | 1 | Write-protect, active low |
| byte_n | input | 1 | Width select: 1 = word, 0 = byte |
| a9_hv | input | 1 | High-voltage level present on address bit 9 (signature read) |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data bus as seen by the input buffers |
| dq_out | output | 16 | Data to drive on the bus |
| dq_oe_lo | output | 1 | Drive enable for bits 7:0 |
| dq_oe_hi | output | 1 | Drive enable for bits 15:8 |

## Verification
The interesting overlap is a reset-pin assertion in the middle of the busy countdown that follows an accepted program. The reset must clear the countdown and error bits in the same cycle the counter would otherwise decrement, and it must not undo the array write that has already been made. The bench programs a word and then pulls the reset pin low a few clocks later, while busy is still counting. After release it expects status to read 0x80 at once, array reads to be the default mode, and the programmed word to hold the new AND value.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

   typedef enum logic [1:0] {
      MD_ARRAY  = 2'd0,
      MD_STATUS = 2'd1,
      MD_SETUP  = 2'd2
   } bbf_mode_e;

   localparam logic [7:0] OP_READ  = 8'hFF;
   localparam logic [7:0] OP_PROG  = 8'h40;
   localparam logic [7:0] OP_STAT  = 8'h70;
   localparam logic [7:0] OP_CLEAR = 8'h50;

   localparam int ST_READY = 7;
   localparam int ST_PERR  = 4;
   localparam int ST_LOCK  = 1;

endpackage

// File: rtl/bbf_sync.sv
module bbf_sync #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   // Every synchronized pin is active low, so it resets to idle high.
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= 2'b11;
         else        ff <= {ff[0], d[i]};
      end
      assign q[i] = ff[1];
   end
endmodule

// File: rtl/bbf_array.sv
module bbf_array #(
   parameter int AW = 4,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [DW/8-1:0] wlane,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   localparam int NL    = DW / 8;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] old_w, new_w, lmask;

   assign old_w = mem[waddr];
   assign rdata = mem[raddr];

   // Per lane: an enabled lane may only clear bits, a disabled lane keeps its value.
   for (genvar l = 0; l < NL; l++) begin : g_lane
      assign lmask[l*8 +: 8] = {8{wlane[l]}};
      assign new_w[l*8 +: 8] = wlane[l] ? (old_w[l*8 +: 8] & wdata[l*8 +: 8])
                                        :  old_w[l*8 +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (we) begin
         mem[waddr] <= new_w;
      end
   end

   a_r9_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((mem[$past(waddr)] & ~$past(old_w)) == '0));

   a_r7_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (((mem[$past(waddr)] ^ $past(old_w)) & ~$past(lmask)) == '0));
endmodule

// File: rtl/bbf_cmd_fsm.sv
module bbf_cmd_fsm
   import bbf_pkg::*;
#(
   parameter int AW          = 4,
   parameter int BOOT_WORDS  = 4,
   parameter int BUSY_CYCLES = 40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rp_s,
   input  logic          stb,
   input  logic [7:0]    cmd,
   input  logic [AW-1:0] waddr,
   input  logic          wp_ok,
   output bbf_mode_e     mode,
   output logic [7:0]    status,
   output logic          arr_we
);
   localparam int CW = $clog2(BUSY_CYCLES + 1);
   localparam logic [AW:0]   BOOT_LIM = (AW+1)'(BOOT_WORDS);
   localparam logic [CW-1:0] BUSY_LD  = CW'(BUSY_CYCLES);

   logic [CW-1:0] cnt;
   logic          perr, lock, busy, in_boot, refuse, take;

   assign busy    = (cnt != '0);
   assign in_boot = ({1'b0, waddr} < BOOT_LIM);
   assign refuse  = in_boot && !wp_ok;
   assign take    = stb && !busy;
   assign arr_we  = take && (mode == MD_SETUP) && !refuse;
   assign status  = {~busy, 2'b00, perr, 2'b00, lock, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MD_ARRAY;
         cnt  <= '0;
         perr <= 1'b0;
         lock <= 1'b0;
      end else if (!rp_s) begin
         mode <= MD_ARRAY;
         cnt  <= '0;
         perr <= 1'b0;
         lock <= 1'b0;
      end else begin
         if (busy) cnt <= cnt - 1'b1;
         if (take) begin
            if (mode == MD_SETUP) begin
               mode <= MD_STATUS;
               if (refuse) begin
                  perr <= 1'b1;
                  lock <= 1'b1;
               end else begin
                  cnt <= BUSY_LD;
               end
            end else begin
               case (cmd)
                  OP_PROG:  mode <= MD_SETUP;
                  OP_STAT:  mode <= MD_STATUS;
                  OP_CLEAR: begin perr <= 1'b0; lock <= 1'b0; end
                  default:  mode <= MD_ARRAY;
               endcase
            end
         end
      end
   end

   a_r4_pin_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !rp_s |=> (mode == MD_ARRAY && status == 8'h80));

   a_r2_second_write: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mode == MD_SETUP) |=> (mode == MD_STATUS));

   a_r5_refuse_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mode == MD_SETUP && in_boot && !wp_ok)
         |=> (status[ST_PERR] && status[ST_LOCK]));

   a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |=> !status[ST_READY]);

   a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && busy) |=> (mode == $past(mode)));
endmodule

// File: rtl/bbf_out_sel.sv
module bbf_out_sel
   import bbf_pkg::*;
#(
   parameter logic [15:0] MFR_ID = 16'h00A5,
   parameter logic [15:0] DEV_ID = 16'h7E21
) (
   input  bbf_mode_e   mode,
   input  logic [7:0]  status,
   input  logic [15:0] arr_word,
   input  logic        a9_hv,
   input  logic        a0,
   input  logic        byte_n,
   input  logic        bsel,
   input  logic        ce_n,
   input  logic        oe_n,
   input  logic        rp_n,
   output logic [15:0] dq_out,
   output logic        oe_lo,
   output logic        oe_hi
);
   logic [15:0] word_v, sel_v;

   always_comb begin
      if (a9_hv)                  word_v = a0 ? DEV_ID : MFR_ID;
      else if (mode != MD_ARRAY)  word_v = {8'h00, status};
      else                        word_v = arr_word;

      // In byte mode only array reads use the extra address bit.
      if (byte_n)
         sel_v = word_v;
      else if (!a9_hv && mode == MD_ARRAY && bsel)
         sel_v = {8'h00, word_v[15:8]};
      else
         sel_v = {8'h00, word_v[7:0]};
   end

   assign oe_lo  = !ce_n && !oe_n && rp_n;
   assign oe_hi  = oe_lo && byte_n;
   assign dq_out = oe_lo ? sel_v : 16'h0000;
endmodule

// File: rtl/bbf_host_port.sv
module bbf_host_port
   import bbf_pkg::*;
#(
   parameter int          AW          = 4,
   parameter int          BOOT_WORDS  = 4,
   parameter int          BUSY_CYCLES = 40,
   parameter logic [15:0] MFR_ID      = 16'h00A5,
   parameter logic [15:0] DEV_ID      = 16'h7E21
) (
   input  logic          clk,
   input  logic          sys_rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          rp_n,
   input  logic          rp_hv,
   input  logic          wp_n,
   input  logic          byte_n,
   input  logic          a9_hv,
   input  logic [AW-1:0] addr,
   input  logic [15:0]   dq_in,
   output logic [15:0]   dq_out,
   output logic          dq_oe_lo,
   output logic          dq_oe_hi
);
   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("bbf_host_port: AW must lie in 1..10");
   end
   if (BOOT_WORDS < 1 || BOOT_WORDS > (1 << AW)) begin : g_bad_boot
      $error("bbf_host_port: BOOT_WORDS must lie in 1..2**AW");
   end
   if (BUSY_CYCLES < 2) begin : g_bad_busy
      $error("bbf_host_port: BUSY_CYCLES must be at least 2");
   end

   logic ce_s, we_s, rp_s, we_prev, stb_raw, stb_d;
   logic [AW-1:0] lat_addr;
   logic [15:0]   lat_data, wdata, arr_word;
   logic [1:0]    wlane;
   logic          lat_byte, lat_wp_ok, arr_we;
   logic [7:0]    status;
   bbf_mode_e     mode;

   bbf_sync #(.W(3)) u_sync (
      .clk(clk), .rst_n(sys_rst_n),
      .d({ce_n, we_n, rp_n}), .q({ce_s, we_s, rp_s})
   );

   assign stb_raw = we_s && !we_prev && !ce_s && rp_s;

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         we_prev   <= 1'b1;
         stb_d     <= 1'b0;
         lat_addr  <= '0;
         lat_data  <= '0;
         lat_byte  <= 1'b0;
         lat_wp_ok <= 1'b0;
      end else begin
         we_prev <= we_s;
         stb_d   <= stb_raw && rp_s;
         if (stb_raw) begin
            lat_addr  <= addr;
            lat_data  <= dq_in;
            lat_byte  <= !byte_n;
            lat_wp_ok <= wp_n || rp_hv;
         end
      end
   end

   always_comb begin
      if (lat_byte) begin
         wdata = {2{lat_data[7:0]}};
         wlane = lat_data[15] ? 2'b10 : 2'b01;
      end else begin
         wdata = lat_data;
         wlane = 2'b11;
      end
   end

   bbf_cmd_fsm #(.AW(AW), .BOOT_WORDS(BOOT_WORDS), .BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
      .clk(clk), .rst_n(sys_rst_n), .rp_s(rp_s), .stb(stb_d),
      .cmd(lat_data[7:0]), .waddr(lat_addr), .wp_ok(lat_wp_ok),
      .mode(mode), .status(status), .arr_we(arr_we)
   );

   bbf_array #(.AW(AW), .DW(16)) u_array (
      .clk(clk), .rst_n(sys_rst_n), .we(arr_we), .waddr(lat_addr),
      .wdata(wdata), .wlane(wlane), .raddr(addr), .rdata(arr_word)
   );

   bbf_out_sel #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_out (
      .mode(mode), .status(status), .arr_word(arr_word), .a9_hv(a9_hv),
      .a0(addr[0]), .byte_n(byte_n), .bsel(dq_in[15]), .ce_n(ce_n),
      .oe_n(oe_n), .rp_n(rp_n), .dq_out(dq_out), .oe_lo(dq_oe_lo),
      .oe_hi(dq_oe_hi)
   );

   a_r1_select_needed: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (we_s && !we_prev && ce_s) |=> !stb_d);

   a_r3_float_on_reset: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !rp_n |-> (!dq_oe_lo && !dq_oe_hi && dq_out == 16'h0000));
endmodule

// File: tb/tb_bbf_host_port.sv
module tb_bbf_host_port;
   logic clk = 1'b0;
   logic sys_rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1;
   logic rp_hv = 1'b0, wp_n = 1'b1, byte_n = 1'b1, a9_hv = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] dq_in = '0;
   logic [15:0] dq_out;
   logic dq_oe_lo, dq_oe_hi;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bbf_host_port dut (
      .clk(clk), .sys_rst_n(sys_rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .rp_n(rp_n), .rp_hv(rp_hv), .wp_n(wp_n), .byte_n(byte_n), .a9_hv(a9_hv),
      .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe_lo(dq_oe_lo),
      .dq_oe_hi(dq_oe_hi)
   );

   task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; dq_in = d; ce_n = 1'b0;
      repeat (2) @(negedge clk);
      we_n = 1'b0;
      repeat (3) @(negedge clk);
      we_n = 1'b1;
      repeat (5) @(negedge clk);
      ce_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   // Returns {oe_hi, oe_lo, dq_out}.
   task automatic bus_read(input logic [3:0] a, input logic b15, output logic [17:0] r);
      @(negedge clk);
      addr = a; dq_in = {b15, 15'h0}; ce_n = 1'b0; oe_n = 1'b0;
      repeat (2) @(negedge clk);
      r = {dq_oe_hi, dq_oe_lo, dq_out};
      ce_n = 1'b1; oe_n = 1'b1; dq_in = '0;
   endtask

   task automatic program_word(input logic [3:0] a, input logic [15:0] d);
      bus_write(a, 16'h0040);
      bus_write(a, d);
      repeat (50) @(negedge clk);
      bus_write(a, 16'h00FF);
   endtask

   task automatic t_reset_state;
      logic [17:0] r;
      chk("R3 idle", {dq_oe_hi, dq_oe_lo, dq_out}, 18'h0);
      bus_read(4'd5, 1'b0, r);
      chk("R4 reset reads array", r, {2'b11, 16'hFFFF});
      bus_write(4'd0, 16'h0070);
      bus_read(4'd0, 1'b0, r);
      chk("R10 ready after reset", r, {2'b11, 16'h0080});
      bus_write(4'd0, 16'h00FF);
   endtask

   task automatic t_r1_no_select;
      logic [17:0] r;
      @(negedge clk);
      addr = 4'd6; dq_in = 16'h0070;
      we_n = 1'b0; repeat (3) @(negedge clk);
      we_n = 1'b1; repeat (6) @(negedge clk);
      bus_read(4'd6, 1'b0, r);
      chk("R1 write without select ignored", r, {2'b11, 16'hFFFF});
   endtask

   task automatic t_program_busy;
      logic [17:0] r;
      bus_write(4'd6, 16'h0040);
      bus_read(4'd6, 1'b0, r);
      chk("R2 first cycle shows status only", r, {2'b11, 16'h0080});
      bus_write(4'd6, 16'h1234);
      bus_read(4'd6, 1'b0, r);
      chk("R10 busy after program", r, {2'b11, 16'h0000});
      bus_write(4'd6, 16'h00FF);
      bus_read(4'd6, 1'b0, r);
      chk("R10 write during busy ignored", r, {2'b11, 16'h0000});
      repeat (50) @(negedge clk);
      bus_read(4'd6, 1'b0, r);
      chk("R10 ready after countdown", r, {2'b11, 16'h0080});
      bus_write(4'd6, 16'h00FF);
      bus_read(4'd6, 1'b0, r);
      chk("R2 second cycle data stored", r, {2'b11, 16'h1234});
      program_word(4'd6, 16'hFF0F);
      bus_read(4'd6, 1'b0, r);
      chk("R9 AND with old word", r, {2'b11, 16'h1204});
   endtask

   task automatic t_r5_lock;
      logic [17:0] r;
      wp_n = 1'b0;
      bus_write(4'd2, 16'h0040);
      bus_write(4'd2, 16'h0000);
      bus_read(4'd2, 1'b0, r);
      chk("R5 refused status", r, {2'b11, 16'h0092});
      bus_write(4'd2, 16'h00FF);
      bus_read(4'd2, 1'b0, r);
      chk("R5 boot word unchanged", r, {2'b11, 16'hFFFF});
      bus_write(4'd2, 16'h0050);
      bus_write(4'd2, 16'h0070);
      bus_read(4'd2, 1'b0, r);
      chk("R8 clear status", r, {2'b11, 16'h0080});
      rp_hv = 1'b1;
      program_word(4'd2, 16'h00F0);
      rp_hv = 1'b0;
      bus_read(4'd2, 1'b0, r);
      chk("R5 high-voltage override", r, {2'b11, 16'h00F0});
      program_word(4'd9, 16'hAAAA);
      bus_read(4'd9, 1'b0, r);
      chk("R5 main block unaffected by protect", r, {2'b11, 16'hAAAA});
      wp_n = 1'b1;
      program_word(4'd3, 16'h0F00);
      bus_read(4'd3, 1'b0, r);
      chk("R5 protect high allows boot", r, {2'b11, 16'h0F00});
   endtask

   task automatic t_r8_low_byte;
      logic [17:0] r;
      bus_write(4'd0, 16'h1270);
      bus_read(4'd6, 1'b0, r);
      chk("R8 upper bits ignored", r, {2'b11, 16'h0080});
      bus_write(4'd0, 16'h3C20);
      bus_read(4'd6, 1'b0, r);
      chk("R8 unknown byte selects array", r, {2'b11, 16'h1204});
   endtask

   task automatic t_r6_signature;
      logic [17:0] r;
      a9_hv = 1'b1;
      bus_read(4'd0, 1'b0, r);
      chk("R6 manufacturer id", r, {2'b11, 16'h00A5});
      bus_read(4'd1, 1'b0, r);
      chk("R6 device id", r, {2'b11, 16'h7E21});
      byte_n = 1'b0;
      bus_read(4'd1, 1'b1, r);
      chk("R6 byte id pin15=1", r, {2'b01, 16'h0021});
      bus_read(4'd1, 1'b0, r);
      chk("R6 byte id pin15=0", r, {2'b01, 16'h0021});
      byte_n = 1'b1;
      a9_hv = 1'b0;
   endtask

   task automatic t_r7_byte;
      logic [17:0] r;
      byte_n = 1'b0;
      bus_read(4'd6, 1'b0, r);
      chk("R7 low byte", r, {2'b01, 16'h0004});
      bus_read(4'd6, 1'b1, r);
      chk("R7 high byte", r, {2'b01, 16'h0012});
      program_word(4'd9, 16'h800F);
      byte_n = 1'b1;
      bus_read(4'd9, 1'b0, r);
      chk("R7 byte program high lane only", r, {2'b11, 16'h0AAA});
   endtask

   task automatic t_r3_float;
      logic [17:0] r;
      @(negedge clk);
      addr = 4'd6; ce_n = 1'b0; oe_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R3 output enable high", {dq_oe_hi, dq_oe_lo, dq_out}, 18'h0);
      oe_n = 1'b0; rp_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R3 reset pin low", {dq_oe_hi, dq_oe_lo, dq_out}, 18'h0);
      ce_n = 1'b1; oe_n = 1'b1; rp_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_read(4'd6, 1'b0, r);
      chk("R3 drive resumes", r, {2'b11, 16'h1204});
   endtask

   task automatic t_r4_cancel;
      logic [17:0] r;
      bus_write(4'd9, 16'h0040);
      @(negedge clk); rp_n = 1'b0;
      repeat (4) @(negedge clk); rp_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_read(4'd9, 1'b0, r);
      chk("R4 read array after reset pin", r, {2'b11, 16'h0AAA});
      bus_write(4'd9, 16'h0000);
      bus_read(4'd9, 1'b0, r);
      chk("R4 setup cancelled", r, {2'b11, 16'h0AAA});
   endtask

   // Reset pin asserted while the busy countdown is running.
   task automatic t_r4_reset_in_busy;
      logic [17:0] r;
      bus_write(4'd10, 16'h0040);
      bus_write(4'd10, 16'h5555);
      rp_n = 1'b0;
      repeat (3) @(negedge clk);
      rp_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_read(4'd10, 1'b0, r);
      chk("R4 array mode after reset in busy", r, {2'b11, 16'h5555});
      bus_write(4'd0, 16'h0070);
      bus_read(4'd0, 1'b0, r);
      chk("R4 busy cleared by reset pin", r, {2'b11, 16'h0080});
      bus_write(4'd0, 16'h00FF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      sys_rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset_state();
      t_r1_no_select();
      t_program_busy();
      t_r5_lock();
      t_r8_low_byte();
      t_r6_signature();
      t_r7_byte();
      t_r3_float();
      t_r4_cancel();
      t_r4_reset_in_busy();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule